// File: doc/BRIEF.md
# Three-Layer Pixel Compositor

This block forms the final colour of every display pixel from three stacked layers. At the bottom sits a background: either the pixel of an external digital video stream or one programmable flat border colour. Above it lies the bitmap layer, which is mixed into the background with a 6-bit weight giving 64 steps. On top sits a 32x32 hardware cursor, or a full-screen cross-hair formed by the cursor's row and column.

It runs in the dot-clock domain, at rates up to about 40 MHz. It takes the raster position and a blank flag from the timing generator. It takes the bitmap pixel from the display fetch path, the cursor row data for the current line from the cursor fetch, and the external video pixel from the capture path. The result and its blank flag are registered once and then go to the DAC or digital output stage.

Top module: `screen_mixer`

## Requirements
- R1: While rst_n is low, out_rgb is 0 and out_blank is 1.
- R2: Every input change is reflected at out_rgb and out_blank exactly one clock edge later; out_blank is blank_in delayed by one cycle.
- R3: When blank_in is 1, out_rgb becomes 0 regardless of every other input.
- R4: Per 8-bit channel the mixed value is (alpha*bitmap + (63-alpha)*background + 31) / 63 with integer division, so alpha 63 yields the bitmap exactly and alpha 0 yields the background exactly.
- R5: bg_sel 0 selects ext_rgb as the background, and bg_sel 1 selects border_rgb.
- R6: In pattern mode the cursor covers pixels with 0 <= pix_x-cur_x < 32 and 0 <= pix_y-cur_y < 32. cur_row holds the 2-bit codes for the current line, and column c = pix_x-cur_x reads bits [2c+1:2c]. Outside the window the cursor has no effect.
- R7: Code 0 is transparent and leaves the mixed value. Code 1 replaces it with cur_col0 and code 2 with cur_col1.
- R8: Code 3 outputs the bitwise inverse of the mixed value.
- R9: With cur_xhair 1, a pixel whose pix_x equals cur_x or whose pix_y equals cur_y takes cur_col0, and every other pixel shows the mixed value; cur_row is ignored.
- R10: With cur_en 0, the cursor has no effect in either mode.
- RGB packing on all colour ports is red in [23:16], green in [15:8], blue in [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_x | input | 11 | Current pixel column |
| pix_y | input | 10 | Current line |
| blank_in | input | 1 | Pixel lies outside the active area |
| bmp_rgb | input | 24 | Bitmap layer pixel |
| ext_rgb | input | 24 | External video pixel |
| border_rgb | input | 24 | Flat border colour |
| bg_sel | input | 1 | Background source: 0 external, 1 border |
| alpha | input | 6 | Bitmap weight, 0 to 63 |
| cur_en | input | 1 | Cursor layer enable |
| cur_xhair | input | 1 | 1 selects cross-hair mode |
| cur_x | input | 11 | Cursor column origin |
| cur_y | input | 10 | Cursor line origin |
| cur_row | input | 64 | 32 cursor codes for the current line, column c in bits [2c+1:2c] |
| cur_col0 | input | 24 | Cursor colour for code 1 and the cross-hair |
| cur_col1 | input | 24 | Cursor colour for code 2 |
| out_rgb | output | 24 | Composited pixel |
| out_blank | output | 1 | Blank flag aligned with out_rgb |

## Verification
Every result is due on the first rising edge after the inputs that produce it, because a single register stage sits between inputs and outputs. The driver applies each stimulus on a falling edge and queues its expected pixel and blank flag. The monitor pops one entry 2 ns after each following rising edge, so every comparison lands in the cycle where that result first appears. Back-to-back stimuli with different values confirm that each output belongs to its own input cycle and not to a neighbouring one.

// File: rtl/mix_pkg.sv
package mix_pkg;
    typedef enum logic [1:0] {
        CUR_CLEAR = 2'd0,
        CUR_COL0  = 2'd1,
        CUR_COL1  = 2'd2,
        CUR_INV   = 2'd3
    } cur_code_e;
endpackage

// File: rtl/mix_blend.sv
module mix_blend #(
    parameter int CW = 8,
    parameter int AW = 6
) (
    input  logic [CW-1:0] fg,
    input  logic [CW-1:0] bg,
    input  logic [AW-1:0] alpha,
    output logic [CW-1:0] res
);
    localparam int AMAX = (1 << AW) - 1;
    localparam int PW   = CW + AW + 1;

    logic [PW-1:0] a_w, na_w, sum_w, quo_w;

    always_comb begin
        a_w   = PW'(alpha);
        na_w  = PW'(AMAX) - a_w;
        sum_w = a_w * PW'(fg) + na_w * PW'(bg) + PW'(AMAX / 2);
        quo_w = sum_w / PW'(AMAX);
        res   = quo_w[CW-1:0];
    end
endmodule

// File: rtl/mix_cursor.sv
module mix_cursor #(
    parameter int XW  = 11,
    parameter int YW  = 10,
    parameter int CUR = 32
) (
    input  logic [XW-1:0]      pix_x,
    input  logic [YW-1:0]      pix_y,
    input  logic [XW-1:0]      cur_x,
    input  logic [YW-1:0]      cur_y,
    input  logic               en,
    input  logic               xhair,
    input  logic [2*CUR-1:0]   row,
    output mix_pkg::cur_code_e code
);
    import mix_pkg::*;
    localparam int CIW = $clog2(CUR);

    logic [XW:0]      dx;
    logic [YW:0]      dy;
    logic             in_win;
    logic [2*CUR-1:0] shifted;

    always_comb begin
        dx      = {1'b0, pix_x} - {1'b0, cur_x};
        dy      = {1'b0, pix_y} - {1'b0, cur_y};
        in_win  = !dx[XW] && (dx < (XW+1)'(CUR)) && !dy[YW] && (dy < (YW+1)'(CUR));
        shifted = row >> {dx[CIW-1:0], 1'b0};
        code    = CUR_CLEAR;
        if (en) begin
            if (xhair) begin
                if (pix_x == cur_x || pix_y == cur_y) code = CUR_COL0;
            end else if (in_win) begin
                code = cur_code_e'(shifted[1:0]);
            end
        end
    end
endmodule

// File: rtl/screen_mixer.sv
module screen_mixer #(
    parameter int CW  = 8,
    parameter int AW  = 6,
    parameter int XW  = 11,
    parameter int YW  = 10,
    parameter int CUR = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XW-1:0]     pix_x,
    input  logic [YW-1:0]     pix_y,
    input  logic              blank_in,
    input  logic [3*CW-1:0]   bmp_rgb,
    input  logic [3*CW-1:0]   ext_rgb,
    input  logic [3*CW-1:0]   border_rgb,
    input  logic              bg_sel,
    input  logic [AW-1:0]     alpha,
    input  logic              cur_en,
    input  logic              cur_xhair,
    input  logic [XW-1:0]     cur_x,
    input  logic [YW-1:0]     cur_y,
    input  logic [2*CUR-1:0]  cur_row,
    input  logic [3*CW-1:0]   cur_col0,
    input  logic [3*CW-1:0]   cur_col1,
    output logic [3*CW-1:0]   out_rgb,
    output logic              out_blank
);
    import mix_pkg::*;
    localparam int PXW = 3 * CW;

    typedef struct packed {
        logic [PXW-1:0] rgb;
        logic           blank;
    } stage_t;

    stage_t         st_d, st_q;
    logic [PXW-1:0] back_rgb;
    logic [PXW-1:0] mixed_rgb;
    cur_code_e      code;

    assign back_rgb = bg_sel ? border_rgb : ext_rgb;

    for (genvar ch = 0; ch < 3; ch++) begin : g_chan
        mix_blend #(.CW(CW), .AW(AW)) u_blend (
            .fg    (bmp_rgb[ch*CW +: CW]),
            .bg    (back_rgb[ch*CW +: CW]),
            .alpha (alpha),
            .res   (mixed_rgb[ch*CW +: CW])
        );
    end

    mix_cursor #(.XW(XW), .YW(YW), .CUR(CUR)) u_cursor (
        .pix_x (pix_x),
        .pix_y (pix_y),
        .cur_x (cur_x),
        .cur_y (cur_y),
        .en    (cur_en),
        .xhair (cur_xhair),
        .row   (cur_row),
        .code  (code)
    );

    always_comb begin
        st_d.blank = blank_in;
        case (code)
            CUR_COL0: st_d.rgb = cur_col0;
            CUR_COL1: st_d.rgb = cur_col1;
            CUR_INV:  st_d.rgb = ~mixed_rgb;
            default:  st_d.rgb = mixed_rgb;
        endcase
        if (blank_in) st_d.rgb = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rgb   <= '0;
            st_q.blank <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_rgb   = st_q.rgb;
    assign out_blank = st_q.blank;
endmodule

// File: rtl/mix_checker.sv
module mix_checker #(
    parameter int CW = 8,
    parameter int AW = 6,
    parameter int XW = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic            blank_in,
    input logic            bg_sel,
    input logic [AW-1:0]   alpha,
    input logic            cur_en,
    input logic            cur_xhair,
    input logic [XW-1:0]   pix_x,
    input logic [XW-1:0]   cur_x,
    input logic [3*CW-1:0] bmp_rgb,
    input logic [3*CW-1:0] ext_rgb,
    input logic [3*CW-1:0] border_rgb,
    input logic [3*CW-1:0] cur_col0,
    input logic [3*CW-1:0] out_rgb,
    input logic            out_blank
);
    localparam logic [AW-1:0] AFULL = '1;

    always @(negedge clk) begin
        if (!rst_n) begin
            a_reset_r1: assert (out_rgb == '0 && out_blank == 1'b1);
        end
    end

    p_blank_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_blank == $past(blank_in));

    p_blank_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        blank_in |=> out_rgb == '0);

    p_alpha_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_in && !cur_en && alpha == AFULL) |=> out_rgb == $past(bmp_rgb));

    p_border_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_in && !cur_en && alpha == '0 && bg_sel) |=> out_rgb == $past(border_rgb));

    p_xhair_col_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_in && cur_en && cur_xhair && pix_x == cur_x) |=> out_rgb == $past(cur_col0));

    p_cursor_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_in && !cur_en && alpha == '0 && !bg_sel) |=> out_rgb == $past(ext_rgb));
endmodule

bind screen_mixer mix_checker #(.CW(CW), .AW(AW), .XW(XW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .blank_in   (blank_in),
    .bg_sel     (bg_sel),
    .alpha      (alpha),
    .cur_en     (cur_en),
    .cur_xhair  (cur_xhair),
    .pix_x      (pix_x),
    .cur_x      (cur_x),
    .bmp_rgb    (bmp_rgb),
    .ext_rgb    (ext_rgb),
    .border_rgb (border_rgb),
    .cur_col0   (cur_col0),
    .out_rgb    (out_rgb),
    .out_blank  (out_blank)
);

// File: tb/tb_screen_mixer.sv
module tb_screen_mixer;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] pix_x = '0;
    logic [9:0]  pix_y = '0;
    logic        blank_in = 1'b0;
    logic [23:0] bmp_rgb = '0, ext_rgb = '0, border_rgb = '0;
    logic        bg_sel = 1'b0;
    logic [5:0]  alpha = '0;
    logic        cur_en = 1'b0, cur_xhair = 1'b0;
    logic [10:0] cur_x = '0;
    logic [9:0]  cur_y = '0;
    logic [63:0] cur_row = '0;
    logic [23:0] cur_col0 = '0, cur_col1 = '0;
    logic [23:0] out_rgb;
    logic        out_blank;

    int tests = 0;
    int fails = 0;
    logic [23:0] q_rgb[$];
    logic        q_blank[$];
    string       q_tag[$];

    always #(PERIOD/2) clk = ~clk;

    screen_mixer dut (
        .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
        .blank_in(blank_in), .bmp_rgb(bmp_rgb), .ext_rgb(ext_rgb),
        .border_rgb(border_rgb), .bg_sel(bg_sel), .alpha(alpha),
        .cur_en(cur_en), .cur_xhair(cur_xhair), .cur_x(cur_x), .cur_y(cur_y),
        .cur_row(cur_row), .cur_col0(cur_col0), .cur_col1(cur_col1),
        .out_rgb(out_rgb), .out_blank(out_blank)
    );

    function automatic logic [7:0] mix8(input int a, input int f, input int b);
        return 8'((a * f + (63 - a) * b + 31) / 63);
    endfunction

    function automatic logic [23:0] model();
        logic [23:0] bg, m, r;
        int dx, dy;
        logic [1:0] c;
        bg = bg_sel ? border_rgb : ext_rgb;
        for (int k = 0; k < 3; k++)
            m[k*8 +: 8] = mix8(int'(alpha), int'(bmp_rgb[k*8 +: 8]), int'(bg[k*8 +: 8]));
        r = m;
        dx = int'(pix_x) - int'(cur_x);
        dy = int'(pix_y) - int'(cur_y);
        if (cur_en && cur_xhair) begin
            if (dx == 0 || dy == 0) r = cur_col0;
        end else if (cur_en && dx >= 0 && dx < 32 && dy >= 0 && dy < 32) begin
            c = cur_row[2*dx +: 2];
            case (c)
                2'd1: r = cur_col0;
                2'd2: r = cur_col1;
                2'd3: r = ~m;
                default: r = m;
            endcase
        end
        if (blank_in) r = '0;
        return r;
    endfunction

    task automatic send(input string tag);
        q_rgb.push_back(model());
        q_blank.push_back(blank_in);
        q_tag.push_back(tag);
    endtask

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #2;
            if (q_rgb.size() > 0) begin
                automatic logic [23:0] er = q_rgb.pop_front();
                automatic logic        eb = q_blank.pop_front();
                automatic string       et = q_tag.pop_front();
                check({et, " rgb"}, out_rgb, er);
                check({et, " blank R2"}, {23'd0, out_blank}, {23'd0, eb});
            end
        end
    end

    initial begin : watchdog
        #(PERIOD * 5000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : driver
        bmp_rgb = 24'hC83C10; ext_rgb = 24'h0A64F0; border_rgb = 24'h203040;
        alpha = 6'd20; blank_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset rgb", out_rgb, 24'h0);
        check("R1 reset blank", {23'd0, out_blank}, 24'd1);
        rst_n = 1'b1;

        // R3 blank forces zero, R2 blank flag follows
        @(negedge clk); blank_in = 1'b1; alpha = 6'd63; send("R3 blank");
        // R4 full weight gives bitmap, R2 back-to-back
        @(negedge clk); blank_in = 1'b0; send("R4 alpha63");
        @(negedge clk); alpha = 6'd0; send("R4 R5 alpha0 ext");
        @(negedge clk); bg_sel = 1'b1; send("R5 alpha0 border");
        @(negedge clk); alpha = 6'd32; send("R4 mid border");
        @(negedge clk); bg_sel = 1'b0; alpha = 6'd1; send("R4 low ext");
        @(negedge clk); alpha = 6'd47; bmp_rgb = 24'hFF00FF; ext_rgb = 24'h00FF80; send("R4 mix2");

        // Cursor pattern mode
        cur_en = 1'b1; cur_x = 11'd100; cur_y = 10'd50;
        cur_col0 = 24'h112233; cur_col1 = 24'hA5A5A5;
        cur_row = '0;
        cur_row[2*3 +: 2]  = 2'd1;
        cur_row[2*4 +: 2]  = 2'd2;
        cur_row[2*5 +: 2]  = 2'd3;
        cur_row[2*31 +: 2] = 2'd1;
        cur_row[2*0 +: 2]  = 2'd2;
        @(negedge clk); pix_x = 11'd103; pix_y = 10'd60; send("R7 code1");
        @(negedge clk); pix_x = 11'd104; send("R7 code2");
        @(negedge clk); pix_x = 11'd105; send("R8 invert");
        @(negedge clk); pix_x = 11'd106; send("R7 transparent");
        @(negedge clk); pix_x = 11'd131; pix_y = 10'd81; send("R6 last column");
        @(negedge clk); pix_x = 11'd100; pix_y = 10'd50; send("R6 first column");
        @(negedge clk); cur_row = {32{2'b01}}; pix_x = 11'd132; send("R6 right of window");
        @(negedge clk); pix_x = 11'd99; send("R6 left of window");
        @(negedge clk); pix_x = 11'd110; pix_y = 10'd82; send("R6 below window");
        @(negedge clk); pix_y = 10'd49; send("R6 above window");
        @(negedge clk); pix_y = 10'd60; blank_in = 1'b1; send("R3 blank over cursor");
        @(negedge clk); blank_in = 1'b0; cur_en = 1'b0; send("R10 disabled pattern");

        // Cross-hair mode
        @(negedge clk); cur_en = 1'b1; cur_xhair = 1'b1; pix_x = 11'd100; pix_y = 10'd400; send("R9 column match");
        @(negedge clk); pix_x = 11'd700; pix_y = 10'd50; send("R9 row match");
        @(negedge clk); pix_x = 11'd110; pix_y = 10'd60; send("R9 off lines ignores pattern");
        @(negedge clk); cur_en = 1'b0; pix_x = 11'd100; send("R10 disabled crosshair");

        repeat (3) @(negedge clk);
        check("R2 queue drained", 24'(q_rgb.size()), 24'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule